// File: doc/BRIEF.md
# ECC Error Monitor Channel Block

This block watches the diagnostic events reported by the ECC controllers of several RAM arrays and turns them into software-visible state. Each channel receives three event flags from its controller (a corrected single-bit error, an uncorrectable double-bit error, and an error seen during a partial byte write), together with the word index and data word involved. The channel keeps a sticky flag per event kind, raises an interrupt line when an enabled flag is set and the monitor-wide enable is on, and, when capture is switched on, records the failing word index and data.

Software reaches the block through a plain single-cycle register port. A monitor-wide enable register sits at byte address 0x00. Every channel owns a 32-byte register group starting at 0x20 and repeating every 0x20 bytes. Channels may front 32-bit or 64-bit RAMs, chosen per channel by a parameter mask. For a 64-bit RAM the captured data is split across a low and a high register. For a 32-bit RAM the high register always reads zero. Software rebuilds the failing byte address as the RAM base plus the captured index times the RAM word size in bytes.

Top module: `eccmon_top`

## Requirements
- R1: After reset every control, status and capture register reads zero, the monitor-wide enable reads zero, and every interrupt line is low.
- R2: An event flag sets a sticky status bit in the next cycle (status bit 0 = single-bit, bit 1 = double-bit, bit 2 = byte-write). The bit stays set until software clears it.
- R3: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. An event arriving in the same cycle as a clear of its bit leaves that bit set.
- R4: A channel's interrupt is high when the global enable (bit 0 at address 0x00) is set and at least one status bit is set whose type enable in the control register is set. Control bit 1 enables single-bit, bit 2 enables double-bit, and bit 3 enables byte-write.
- R5: When control bit 0 (capture enable) is set, a single-bit or double-bit event loads the event word index into the failing-address register (offset 0x08) and data bits 31:0 into the failing-data-low register (offset 0x0C).
- R6: The failing-data-high register (offset 0x10) loads data bits 63:32 on capture for a channel marked 64-bit in the width mask. For a 32-bit channel it always reads zero.
- R7: With capture disabled, or on a byte-write event alone, the failing-address and failing-data registers keep their values. The status bit is still set.
- R8: A later captured error overwrites the values held from an earlier one.
- R9: Channel c's group starts at 0x20 + 0x20*c, with control at offset 0x00 and status at offset 0x04. Unmapped addresses read zero. Writes to the capture registers are ignored. Channels do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | ADDR_W | Register byte address for reads and writes |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational from busAddr |
| evtSingle | input | NUM_CH | Per-channel single-bit error event |
| evtDouble | input | NUM_CH | Per-channel double-bit error event |
| evtByteWr | input | NUM_CH | Per-channel byte-write error event |
| evtIdx | input | NUM_CH*IDX_W | Per-channel failing word index, valid with an event |
| evtData | input | NUM_CH*64 | Per-channel failing data word, valid with an event |
| irq | output | NUM_CH | Per-channel combined interrupt |

## Verification
The assertions take for granted that each event flag is a clean, known level sampled on every rising edge. They also assume that the index and data lanes are valid in the same cycle as the flag, and that a register write takes exactly one cycle. The stimulus meets these assumptions. It changes every input only on the falling clock edge and pulses event flags for exactly one cycle with their index and data. It returns all event lanes to zero afterwards, and it asserts the write strobe for a single cycle per access.

// File: rtl/eccmon_pkg.sv
package eccmon_pkg;

  // Register-group geometry (byte addresses).
  localparam int GLB_ADDR  = 0;
  localparam int GRP_BASE  = 32;
  localparam int GRP_SHIFT = 5;

  // Offsets inside one channel group.
  localparam logic [GRP_SHIFT-1:0] OFS_CTRL  = 5'h00;
  localparam logic [GRP_SHIFT-1:0] OFS_STAT  = 5'h04;
  localparam logic [GRP_SHIFT-1:0] OFS_FADDR = 5'h08;
  localparam logic [GRP_SHIFT-1:0] OFS_FDLO  = 5'h0C;
  localparam logic [GRP_SHIFT-1:0] OFS_FDHI  = 5'h10;

  // Control register bits.
  localparam int CTRL_CAP = 0;
  localparam int CTRL_SEN = 1;
  localparam int CTRL_DEN = 2;
  localparam int CTRL_BEN = 3;

  // Strobes from the decode/control side to one channel datapath.
  typedef struct packed {
    logic ctrlWr;
    logic statWr;
  } chanStrobe_t;

endpackage

// File: rtl/eccmon_ctrl.sv
module eccmon_ctrl
  import eccmon_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrEn,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    glbWrBit,
  input  logic [NUM_CH*4-1:0]     ctrlAll,
  input  logic [NUM_CH*3-1:0]     statAll,
  input  logic [NUM_CH*IDX_W-1:0] faddrAll,
  input  logic [NUM_CH*32-1:0]    fdloAll,
  input  logic [NUM_CH*32-1:0]    fdhiAll,
  output chanStrobe_t [NUM_CH-1:0] strobes,
  output logic [31:0]             busRdData,
  output logic                    gEn
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GRP_BASE);
  localparam logic [ADDR_W-1:0] NCH_A  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] GLB_A  = ADDR_W'(GLB_ADDR);

  logic [ADDR_W-1:0]    relAddr;
  logic [ADDR_W-1:0]    chSel;
  logic [GRP_SHIFT-1:0] regOfs;
  logic                 inGrp;
  logic                 glbHit;

  assign relAddr = busAddr - BASE_A;
  assign chSel   = relAddr >> GRP_SHIFT;
  assign regOfs  = relAddr[GRP_SHIFT-1:0];
  assign inGrp   = (busAddr >= BASE_A) && (chSel < NCH_A);
  assign glbHit  = (busAddr == GLB_A);

  // Monitor-wide interrupt enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn <= 1'b0;
    end else if (busWrEn && glbHit) begin
      gEn <= glbWrBit;
    end
  end

  // Write strobes per channel.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      strobes[c].ctrlWr = busWrEn && inGrp && (chSel == ADDR_W'(c)) && (regOfs == OFS_CTRL);
      strobes[c].statWr = busWrEn && inGrp && (chSel == ADDR_W'(c)) && (regOfs == OFS_STAT);
    end
  end

  // Read multiplexer.
  always_comb begin
    busRdData = '0;
    if (glbHit) begin
      busRdData = {31'b0, gEn};
    end else if (inGrp) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chSel == ADDR_W'(c)) begin
          case (regOfs)
            OFS_CTRL:  busRdData = 32'(ctrlAll[c*4 +: 4]);
            OFS_STAT:  busRdData = 32'(statAll[c*3 +: 3]);
            OFS_FADDR: busRdData = 32'(faddrAll[c*IDX_W +: IDX_W]);
            OFS_FDLO:  busRdData = fdloAll[c*32 +: 32];
            OFS_FDHI:  busRdData = fdhiAll[c*32 +: 32];
            default:   busRdData = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/eccmon_chan.sv
module eccmon_chan
  import eccmon_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter bit WIDE  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  input  logic [3:0]        wrBits,
  input  logic              gEn,
  input  logic              evtSingle,
  input  logic              evtDouble,
  input  logic              evtByteWr,
  input  logic [IDX_W-1:0]  evtIdx,
  input  logic [63:0]       evtData,
  output logic [3:0]        ctrlQ,
  output logic [2:0]        statQ,
  output logic [IDX_W-1:0]  faddrQ,
  output logic [31:0]       fdloQ,
  output logic [31:0]       fdhiQ,
  output logic              irq
);

  logic [2:0] evtVec;
  logic [2:0] clrMask;
  logic       capHit;

  assign evtVec  = {evtByteWr, evtDouble, evtSingle};
  assign clrMask = strobe.statWr ? wrBits[2:0] : 3'b000;
  assign capHit  = ctrlQ[CTRL_CAP] && (evtSingle || evtDouble);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (strobe.ctrlWr) begin
      ctrlQ <= wrBits;
    end
  end

  // Sticky flags: new events win over a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      statQ <= (statQ & ~clrMask) | evtVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faddrQ <= '0;
      fdloQ  <= '0;
    end else if (capHit) begin
      faddrQ <= evtIdx;
      fdloQ  <= evtData[31:0];
    end
  end

  generate
    if (WIDE) begin : g_wide
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          fdhiQ <= '0;
        end else if (capHit) begin
          fdhiQ <= evtData[63:32];
        end
      end
    end else begin : g_narrow
      logic unusedHi;
      assign unusedHi = ^evtData[63:32];
      assign fdhiQ    = '0;
    end
  endgenerate

  assign irq = gEn && |(statQ & {ctrlQ[CTRL_BEN], ctrlQ[CTRL_DEN], ctrlQ[CTRL_SEN]});

endmodule

// File: rtl/eccmon_top.sv
module eccmon_top
  import eccmon_pkg::*;
#(
  parameter int                NUM_CH    = 5,
  parameter int                IDX_W     = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [NUM_CH-1:0] WIDE_MASK = NUM_CH'(1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrEn,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  input  logic [NUM_CH-1:0]       evtSingle,
  input  logic [NUM_CH-1:0]       evtDouble,
  input  logic [NUM_CH-1:0]       evtByteWr,
  input  logic [NUM_CH*IDX_W-1:0] evtIdx,
  input  logic [NUM_CH*64-1:0]    evtData,
  output logic [NUM_CH-1:0]       irq
);

  chanStrobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH*4-1:0]      ctrlAll;
  logic [NUM_CH*3-1:0]      statAll;
  logic [NUM_CH*IDX_W-1:0]  faddrAll;
  logic [NUM_CH*32-1:0]     fdloAll;
  logic [NUM_CH*32-1:0]     fdhiAll;
  logic                     gEn;
  logic                     unusedWr;

  assign unusedWr = ^busWrData[31:4];

  eccmon_ctrl #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .glbWrBit  (busWrData[0]),
    .ctrlAll   (ctrlAll),
    .statAll   (statAll),
    .faddrAll  (faddrAll),
    .fdloAll   (fdloAll),
    .fdhiAll   (fdhiAll),
    .strobes   (strobes),
    .busRdData (busRdData),
    .gEn       (gEn)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    eccmon_chan #(
      .IDX_W (IDX_W),
      .WIDE  (WIDE_MASK[c])
    ) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobes[c]),
      .wrBits    (busWrData[3:0]),
      .gEn       (gEn),
      .evtSingle (evtSingle[c]),
      .evtDouble (evtDouble[c]),
      .evtByteWr (evtByteWr[c]),
      .evtIdx    (evtIdx[c*IDX_W +: IDX_W]),
      .evtData   (evtData[c*64 +: 64]),
      .ctrlQ     (ctrlAll[c*4 +: 4]),
      .statQ     (statAll[c*3 +: 3]),
      .faddrQ    (faddrAll[c*IDX_W +: IDX_W]),
      .fdloQ     (fdloAll[c*32 +: 32]),
      .fdhiQ     (fdhiAll[c*32 +: 32]),
      .irq       (irq[c])
    );
  end

endmodule

// File: rtl/eccmon_chk.sv
module eccmon_chk #(
  parameter int NUM_CH = 5,
  parameter int IDX_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busWrEn,
  input logic                    gEn,
  input logic [NUM_CH-1:0]       evtSingle,
  input logic [NUM_CH-1:0]       evtDouble,
  input logic [NUM_CH-1:0]       evtByteWr,
  input logic [NUM_CH*IDX_W-1:0] evtIdx,
  input logic [NUM_CH*4-1:0]     ctrlAll,
  input logic [NUM_CH*3-1:0]     statAll,
  input logic [NUM_CH*IDX_W-1:0] faddrAll,
  input logic [NUM_CH-1:0]       irq
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_single_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      evtSingle[c] |=> statAll[c*3]);

    assert_bytewr_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      evtByteWr[c] |=> statAll[c*3+2]);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
      !busWrEn |=> ((statAll[c*3 +: 3] & $past(statAll[c*3 +: 3])) == $past(statAll[c*3 +: 3])));

    assert_irq_needs_global_R4: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] |-> gEn);

    assert_capture_index_R5: assert property (@(posedge clk) disable iff (!rstN)
      (evtSingle[c] && ctrlAll[c*4]) |=> (faddrAll[c*IDX_W +: IDX_W] == $past(evtIdx[c*IDX_W +: IDX_W])));

    assert_hold_without_error_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!evtSingle[c] && !evtDouble[c]) |=> $stable(faddrAll[c*IDX_W +: IDX_W]));
  end

endmodule

bind eccmon_top eccmon_chk #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .gEn       (gEn),
  .evtSingle (evtSingle),
  .evtDouble (evtDouble),
  .evtByteWr (evtByteWr),
  .evtIdx    (evtIdx),
  .ctrlAll   (ctrlAll),
  .statAll   (statAll),
  .faddrAll  (faddrAll),
  .irq       (irq)
);

// File: tb/eccmon_top_bench.sv
module eccmon_top_bench;

  localparam int NCH = 5;
  localparam int IW  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [7:0]        busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NCH-1:0]    evtSingle = '0;
  logic [NCH-1:0]    evtDouble = '0;
  logic [NCH-1:0]    evtByteWr = '0;
  logic [NCH*IW-1:0] evtIdx = '0;
  logic [NCH*64-1:0] evtData = '0;
  logic [NCH-1:0]    irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  eccmon_top u_eccmon_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .evtSingle(evtSingle),
    .evtDouble(evtDouble), .evtByteWr(evtByteWr), .evtIdx(evtIdx),
    .evtData(evtData), .irq(irq)
  );

  // kind: bit0 single, bit1 double, bit2 byte-write. Channel 0 is 64-bit.
  typedef struct packed {
    logic [2:0]  ch;
    logic [2:0]  kind;
    logic [15:0] idx;
    logic [63:0] data;
    logic [2:0]  expStat;
    logic [15:0] expAddr;
    logic [31:0] expLo;
    logic [31:0] expHi;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd0, 3'b001, 16'h0012, 64'h11223344_55667788, 3'b001, 16'h0012, 32'h55667788, 32'h11223344},
    '{3'd1, 3'b010, 16'h0345, 64'hAAAABBBB_CCCCDDDD, 3'b010, 16'h0345, 32'hCCCCDDDD, 32'h0},
    '{3'd2, 3'b100, 16'h0007, 64'h12345678_9ABCDEF0, 3'b100, 16'h0000, 32'h0,        32'h0},
    '{3'd0, 3'b011, 16'h00FF, 64'hDEADBEEF_01234567, 3'b011, 16'h00FF, 32'h01234567, 32'hDEADBEEF},
    '{3'd0, 3'b100, 16'h0055, 64'h99999999_99999999, 3'b100, 16'h00FF, 32'h01234567, 32'hDEADBEEF},
    '{3'd4, 3'b010, 16'hFFFF, 64'hFFFFFFFF_80000001, 3'b010, 16'hFFFF, 32'h80000001, 32'h0},
    '{3'd3, 3'b111, 16'h0001, 64'h00000001_00000002, 3'b111, 16'h0001, 32'h00000002, 32'h0}
  };

  function automatic logic [7:0] regA(int ch, int ofs);
    return 8'(32 + 32 * ch + ofs);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic pulse(int ch, logic [2:0] kind, logic [15:0] idx, logic [63:0] data);
    @(negedge clk);
    evtSingle[ch] = kind[0];
    evtDouble[ch] = kind[1];
    evtByteWr[ch] = kind[2];
    evtIdx[ch*IW +: IW] = idx;
    evtData[ch*64 +: 64] = data;
    @(negedge clk);
    evtSingle = '0; evtDouble = '0; evtByteWr = '0; evtIdx = '0; evtData = '0;
  endtask

  task automatic irqAt(int ch, logic exp, string req);
    @(negedge clk);
    #1;
    check(req, $sformatf("irq ch%0d", ch), 64'(irq[ch]), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busRead(8'h00, v); check("R1", "global", 64'(v), 64'h0);
    for (int c = 0; c < NCH; c++) begin
      busRead(regA(c, 0), v);  check("R1", "ctrl", 64'(v), 64'h0);
      busRead(regA(c, 4), v);  check("R1", "stat", 64'(v), 64'h0);
      busRead(regA(c, 8), v);  check("R1", "faddr", 64'(v), 64'h0);
      busRead(regA(c, 12), v); check("R1", "fdlo", 64'(v), 64'h0);
      busRead(regA(c, 16), v); check("R1", "fdhi", 64'(v), 64'h0);
    end
    #1; check("R1", "irq", 64'(irq), 64'h0);

    busWrite(8'h00, 32'h1);
    for (int c = 0; c < NCH; c++) busWrite(regA(c, 0), 32'hF);
    busRead(regA(3, 0), v); check("R9", "ctrl readback ch3", 64'(v), 64'hF);

    // Vector table: R2 status, R5/R6/R7/R8 capture, R4 irq, R3 clear
    foreach (VECS[i]) begin
      pulse(int'(VECS[i].ch), VECS[i].kind, VECS[i].idx, VECS[i].data);
      busRead(regA(VECS[i].ch, 4), v);  check("R2", $sformatf("vec%0d stat", i), 64'(v), 64'(VECS[i].expStat));
      busRead(regA(VECS[i].ch, 8), v);  check("R5_R7_R8", $sformatf("vec%0d faddr", i), 64'(v), 64'(VECS[i].expAddr));
      busRead(regA(VECS[i].ch, 12), v); check("R5", $sformatf("vec%0d fdlo", i), 64'(v), 64'(VECS[i].expLo));
      busRead(regA(VECS[i].ch, 16), v); check("R6", $sformatf("vec%0d fdhi", i), 64'(v), 64'(VECS[i].expHi));
      irqAt(int'(VECS[i].ch), 1'b1, "R4");
      busWrite(regA(VECS[i].ch, 4), 32'h7);
      busRead(regA(VECS[i].ch, 4), v); check("R3", $sformatf("vec%0d cleared", i), 64'(v), 64'h0);
      irqAt(int'(VECS[i].ch), 1'b0, "R4");
    end

    // R3: partial clear, then set beats clear in the same cycle
    pulse(1, 3'b011, 16'h0010, 64'h0BADF00D_13579BDF);
    busWrite(regA(1, 4), 32'h1);
    busRead(regA(1, 4), v); check("R3", "partial clear", 64'(v), 64'h2);
    @(negedge clk);
    evtSingle[1] = 1'b1; evtIdx[IW +: IW] = 16'h0031; evtData[64 +: 64] = 64'h0000_0000_CAFE_0031;
    busWrEn = 1'b1; busAddr = regA(1, 4); busWrData = 32'h1;
    @(negedge clk);
    evtSingle = '0; evtIdx = '0; evtData = '0; busWrEn = 1'b0; busWrData = '0;
    busRead(regA(1, 4), v); check("R3", "set wins over clear", 64'(v), 64'h3);
    busWrite(regA(1, 4), 32'h7);
    busRead(regA(0, 4), v); check("R9", "ch0 untouched by ch1", 64'(v), 64'h0);

    // R7: capture disabled keeps old values; status still set
    busWrite(regA(1, 0), 32'hE);
    pulse(1, 3'b001, 16'h0222, 64'h77777777_66666666);
    busRead(regA(1, 8), v);  check("R7", "faddr held", 64'(v), 64'h31);
    busRead(regA(1, 12), v); check("R7", "fdlo held", 64'(v), 64'hCAFE0031);
    busRead(regA(1, 16), v); check("R6", "narrow fdhi zero", 64'(v), 64'h0);
    busRead(regA(1, 4), v);  check("R7", "stat still set", 64'(v), 64'h1);
    busWrite(regA(1, 4), 32'h7);

    // R4: type enable masking and global gate
    busWrite(regA(2, 0), 32'h3);
    pulse(2, 3'b100, 16'h0001, 64'h0);
    irqAt(2, 1'b0, "R4");
    busRead(regA(2, 4), v); check("R4", "masked stat", 64'(v), 64'h4);
    pulse(2, 3'b001, 16'h0002, 64'h5);
    irqAt(2, 1'b1, "R4");
    busWrite(8'h00, 32'h0);
    irqAt(2, 1'b0, "R4");
    busWrite(8'h00, 32'h1);
    irqAt(2, 1'b1, "R4");
    busWrite(regA(2, 4), 32'h7);
    irqAt(2, 1'b0, "R4");

    // R9: unmapped reads and ignored writes
    busRead(8'h1C, v); check("R9", "gap below groups", 64'(v), 64'h0);
    busRead(8'h34, v); check("R9", "unused offset", 64'(v), 64'h0);
    busRead(8'hC0, v); check("R9", "beyond last group", 64'(v), 64'h0);
    busWrite(regA(0, 8), 32'h1234);
    busWrite(regA(0, 16), 32'h5678);
    busRead(regA(0, 8), v);  check("R9", "faddr write ignored", 64'(v), 64'hFF);
    busRead(regA(0, 16), v); check("R9", "fdhi write ignored", 64'(v), 64'hDEADBEEF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule